// File: doc/BRIEF.md
# SGMII Rate Adaptation Bridge

This block sits between a byte-wide MAC and a PCS whose byte clock always runs at the gigabit rate. It lets 10 Mb/s and 100 Mb/s traffic cross that fixed-rate link.

On the transmit side it repeats every MAC byte a fixed number of times. It tells the MAC when the next byte is taken with a one-cycle strobe. On the receive side it keeps one byte out of every repeated group and marks it with a byte-valid strobe. Both sides use GMII-style enable, error and data signals. Both directions share one repeat factor. The factor is 100 at 10 Mb/s, 10 at 100 Mb/s and 1 at gigabit.

A mode input picks SGMII or 1000BASE-X. In 1000BASE-X mode the factor is always 1. A new speed or mode setting is only adopted while both directions are idle, so a frame never changes factor partway through. The receive sampling phase restarts at every frame start, so the byte that is kept is always the first copy of each group.

Top module: `rate_bridge`

## Requirements
- R1: While reset is high, and at the first clock after it is released, pcs_tx_en, pcs_tx_er, pcs_tx_d, mac_rx_en, mac_rx_er, mac_rx_d and mac_rx_valid are all 0, and mac_tx_take is 1.
- R2: With sgmii_mode = 1, the speed code gives the factor F as follows: 2'b00 gives F = 100, 2'b01 gives F = 10, and both 2'b10 and 2'b11 give F = 1.
- R3: With sgmii_mode = 0 (1000BASE-X), F = 1 for every speed code.
- R4: mac_tx_take is high for exactly one cycle out of every F cycles. When F = 1 it stays high.
- R5: The values on mac_tx_en, mac_tx_er and mac_tx_d during a cycle with mac_tx_take high appear on pcs_tx_en, pcs_tx_er and pcs_tx_d in the next cycle. They stay there for exactly F cycles.
- R6: The first PCS receive byte of a frame (the cycle pcs_rx_en rises) and every F-th byte after it are forwarded with their er bit. They appear on mac_rx_en, mac_rx_er and mac_rx_d two cycles after they arrive, with mac_rx_valid high for that one cycle.
- R7: Two cycles after pcs_rx_en is low, mac_rx_en and mac_rx_valid are low.
- R8: The receive sampling phase restarts at each rising edge of pcs_rx_en, whatever length the previous frame had.
- R9: A change of sgmii_mode or speed_sel takes effect only at a strobe boundary where both directions are idle. An ongoing frame keeps its factor.
- R10: A frame sent through the transmit side and fed back into the receive side comes out byte-identical, er bits included, at F = 1, 10 and 100 and in 1000BASE-X mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, gigabit rate |
| rst | input | 1 | Synchronous active-high reset |
| sgmii_mode | input | 1 | 1 = SGMII (speed honoured), 0 = 1000BASE-X |
| speed_sel | input | 2 | 00 = 10 Mb/s, 01 = 100 Mb/s, 1x = 1 Gb/s |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_tx_er | input | 1 | MAC transmit error |
| mac_tx_d | input | 8 | MAC transmit byte |
| mac_tx_take | output | 1 | MAC inputs are captured at the end of this cycle |
| pcs_tx_en | output | 1 | Repeated transmit enable to PCS |
| pcs_tx_er | output | 1 | Repeated transmit error to PCS |
| pcs_tx_d | output | 8 | Repeated transmit byte to PCS |
| pcs_rx_en | input | 1 | PCS receive enable |
| pcs_rx_er | input | 1 | PCS receive error |
| pcs_rx_d | input | 8 | PCS receive byte |
| mac_rx_en | output | 1 | Decimated receive enable to MAC |
| mac_rx_er | output | 1 | Decimated receive error to MAC |
| mac_rx_d | output | 8 | Decimated receive byte to MAC |
| mac_rx_valid | output | 1 | High in the cycle a new byte is forwarded |

## Verification
The strobe period is measured for all eight combinations of mode and speed code. This separates the SGMII speed mapping from the 1000BASE-X override.

Looped-back frames with varied byte patterns and a single er byte are sent at every factor. Each transmitted byte is checked cycle by cycle to confirm it is held for exactly F cycles. The receive side is checked for byte-exact recovery, which shows up any phase slip or off-by-one in the group count.

Two directly driven receive frames are sent with lengths that are not multiples of F and a one-cycle gap between them. They show the phase restart and the idle output. A speed change requested in the middle of a frame shows that the factor is only adopted at idle.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              en;
    logic              er;
    logic [BYTE_W-1:0] d;
  } gbyte_t;

  typedef enum logic [1:0] {
    SPD_10     = 2'b00,
    SPD_100    = 2'b01,
    SPD_1G     = 2'b10,
    SPD_1G_ALT = 2'b11
  } speed_e;
endpackage

// File: rtl/rb_factor_ctl.sv
module rb_factor_ctl
  import rb_pkg::*;
#(
  parameter int unsigned SLOW_REP = 100,
  parameter int unsigned MID_REP  = 10,
  parameter int unsigned CW       = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sgmii_mode,
  input  logic [1:0]    speed_sel,
  input  logic          take,
  input  logic          tx_idle,
  input  logic          rx_idle,
  output logic [CW-1:0] fac_act,
  output logic [CW-1:0] fac_next
);
  logic [CW-1:0] fac_req;
  logic          load;

  // Requested factor; 1000BASE-X always runs unrepeated.
  always_comb begin
    fac_req = CW'(1);
    if (sgmii_mode) begin
      case (speed_e'(speed_sel))
        SPD_10:  fac_req = CW'(SLOW_REP);
        SPD_100: fac_req = CW'(MID_REP);
        default: fac_req = CW'(1);
      endcase
    end
  end

  // Adopt a new factor only on a strobe boundary with both paths quiet.
  assign load     = take & tx_idle & rx_idle;
  assign fac_next = load ? fac_req : fac_act;

  always_ff @(posedge clk) begin
    if (rst) fac_act <= fac_req;
    else     fac_act <= fac_next;
  end
endmodule

// File: rtl/rb_tx_repeat.sv
module rb_tx_repeat
  import rb_pkg::*;
#(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] fac_next,
  input  gbyte_t        mac_in,
  output logic          take,
  output gbyte_t        pcs_out
);
  logic [CW-1:0] ph;
  logic [CW-1:0] ph_nxt;

  assign ph_nxt = (ph >= fac_next - CW'(1)) ? '0 : ph + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      take    <= 1'b1;
      pcs_out <= '0;
    end else begin
      ph   <= ph_nxt;
      take <= (ph_nxt == '0);
      if (take) pcs_out <= mac_in;
    end
  end
endmodule

// File: rtl/rb_rx_decim.sv
module rb_rx_decim
  import rb_pkg::*;
#(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] fac_act,
  input  gbyte_t        pcs_in,
  output gbyte_t        mac_out,
  output logic          valid,
  output logic          busy
);
  gbyte_t        stg;
  logic          prev_en;
  logic [CW-1:0] rc;
  logic          rise;
  logic          pick;

  assign rise = stg.en & ~prev_en;
  assign pick = stg.en & (rise | (rc == '0));
  assign busy = stg.en | mac_out.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg     <= '0;
      prev_en <= 1'b0;
      rc      <= '0;
      mac_out <= '0;
      valid   <= 1'b0;
    end else begin
      stg     <= pcs_in;
      prev_en <= stg.en;

      // Group counter, realigned at every frame start.
      if (!stg.en)                        rc <= '0;
      else if (rise)                      rc <= (fac_act > CW'(1)) ? CW'(1) : '0;
      else if (rc >= fac_act - CW'(1))    rc <= '0;
      else                                rc <= rc + CW'(1);

      if (pick) begin
        mac_out <= stg;
        valid   <= 1'b1;
      end else if (stg.en) begin
        valid   <= 1'b0;
      end else begin
        mac_out <= '0;
        valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rate_bridge.sv
module rate_bridge
  import rb_pkg::*;
#(
  parameter int unsigned SLOW_REP = 100,
  parameter int unsigned MID_REP  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sgmii_mode,
  input  logic [1:0]        speed_sel,
  input  logic              mac_tx_en,
  input  logic              mac_tx_er,
  input  logic [BYTE_W-1:0] mac_tx_d,
  output logic              mac_tx_take,
  output logic              pcs_tx_en,
  output logic              pcs_tx_er,
  output logic [BYTE_W-1:0] pcs_tx_d,
  input  logic              pcs_rx_en,
  input  logic              pcs_rx_er,
  input  logic [BYTE_W-1:0] pcs_rx_d,
  output logic              mac_rx_en,
  output logic              mac_rx_er,
  output logic [BYTE_W-1:0] mac_rx_d,
  output logic              mac_rx_valid
);
  localparam int unsigned CW = $clog2(SLOW_REP + 1);

  logic [CW-1:0] fac_act;
  logic [CW-1:0] fac_next;
  logic          take_q;
  logic          rx_busy;
  gbyte_t        tx_in;
  gbyte_t        tx_out;
  gbyte_t        rx_in;
  gbyte_t        rx_out;

  assign tx_in = '{en: mac_tx_en, er: mac_tx_er, d: mac_tx_d};
  assign rx_in = '{en: pcs_rx_en, er: pcs_rx_er, d: pcs_rx_d};

  rb_factor_ctl #(.SLOW_REP(SLOW_REP), .MID_REP(MID_REP), .CW(CW)) u_fac (
    .clk       (clk),
    .rst       (rst),
    .sgmii_mode(sgmii_mode),
    .speed_sel (speed_sel),
    .take      (take_q),
    .tx_idle   (~mac_tx_en & ~tx_out.en),
    .rx_idle   (~pcs_rx_en & ~rx_busy),
    .fac_act   (fac_act),
    .fac_next  (fac_next)
  );

  rb_tx_repeat #(.CW(CW)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .fac_next(fac_next),
    .mac_in  (tx_in),
    .take    (take_q),
    .pcs_out (tx_out)
  );

  rb_rx_decim #(.CW(CW)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .fac_act(fac_act),
    .pcs_in (rx_in),
    .mac_out(rx_out),
    .valid  (mac_rx_valid),
    .busy   (rx_busy)
  );

  assign mac_tx_take = take_q;
  assign pcs_tx_en   = tx_out.en;
  assign pcs_tx_er   = tx_out.er;
  assign pcs_tx_d    = tx_out.d;
  assign mac_rx_en   = rx_out.en;
  assign mac_rx_er   = rx_out.er;
  assign mac_rx_d    = rx_out.d;
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int unsigned SLOW_REP = 100,
  parameter int unsigned MID_REP  = 10,
  parameter int unsigned CW       = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          mac_tx_en,
  input logic          mac_tx_take,
  input logic          pcs_tx_en,
  input logic          pcs_tx_er,
  input logic [7:0]    pcs_tx_d,
  input logic          pcs_rx_en,
  input logic [7:0]    pcs_rx_d,
  input logic          mac_rx_en,
  input logic          mac_rx_valid,
  input logic [7:0]    mac_rx_d,
  input logic [CW-1:0] fac_act,
  input logic [CW-1:0] fac_next
);
  // R2: only the three legal factors are ever active
  p_factor_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (fac_act == CW'(1)) || (fac_act == CW'(MID_REP)) || (fac_act == CW'(SLOW_REP)));

  // R4: a strobe is never followed by another unless the factor is 1
  p_take_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (mac_tx_take && fac_next != CW'(1)) |=> !mac_tx_take);

  // R5: PCS transmit side only changes after a strobe cycle
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !mac_tx_take |=> $stable({pcs_tx_en, pcs_tx_er, pcs_tx_d}));

  // R6: the first byte of a frame is forwarded two cycles later
  p_rx_first_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pcs_rx_en) |-> ##2 (mac_rx_valid && mac_rx_en && mac_rx_d == $past(pcs_rx_d, 2)));

  // R7: receive outputs go quiet two cycles after the PCS does
  p_rx_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !pcs_rx_en |-> ##2 (!mac_rx_en && !mac_rx_valid));

  // R9: the factor changes only after an idle cycle on both paths
  p_factor_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(fac_act)) |-> $past(!mac_tx_en && !pcs_tx_en && !pcs_rx_en));
endmodule

bind rate_bridge rb_checker #(.SLOW_REP(SLOW_REP), .MID_REP(MID_REP), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mac_tx_en   (mac_tx_en),
  .mac_tx_take (mac_tx_take),
  .pcs_tx_en   (pcs_tx_en),
  .pcs_tx_er   (pcs_tx_er),
  .pcs_tx_d    (pcs_tx_d),
  .pcs_rx_en   (pcs_rx_en),
  .pcs_rx_d    (pcs_rx_d),
  .mac_rx_en   (mac_rx_en),
  .mac_rx_valid(mac_rx_valid),
  .mac_rx_d    (mac_rx_d),
  .fac_act     (fac_act),
  .fac_next    (fac_next)
);

// File: tb/rate_bridge_test.sv
module rate_bridge_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sgmii_mode = 1'b1;
  logic [1:0] speed_sel = 2'b10;
  logic       mac_tx_en = 1'b0, mac_tx_er = 1'b0;
  logic [7:0] mac_tx_d = 8'h00;
  logic       mac_tx_take, pcs_tx_en, pcs_tx_er;
  logic [7:0] pcs_tx_d;
  logic       loop = 1'b0;
  logic       drv_en = 1'b0, drv_er = 1'b0;
  logic [7:0] drv_d = 8'h00;
  logic       pcs_rx_en, pcs_rx_er;
  logic [7:0] pcs_rx_d;
  logic       mac_rx_en, mac_rx_er, mac_rx_valid;
  logic [7:0] mac_rx_d;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [7:0] rec_d  [0:63];
  logic       rec_er [0:63];
  int         rec_n;

  always #2 clk = ~clk;

  assign pcs_rx_en = loop ? pcs_tx_en : drv_en;
  assign pcs_rx_er = loop ? pcs_tx_er : drv_er;
  assign pcs_rx_d  = loop ? pcs_tx_d  : drv_d;

  rate_bridge uut (
    .clk(clk), .rst(rst), .sgmii_mode(sgmii_mode), .speed_sel(speed_sel),
    .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er), .mac_tx_d(mac_tx_d),
    .mac_tx_take(mac_tx_take), .pcs_tx_en(pcs_tx_en), .pcs_tx_er(pcs_tx_er),
    .pcs_tx_d(pcs_tx_d), .pcs_rx_en(pcs_rx_en), .pcs_rx_er(pcs_rx_er),
    .pcs_rx_d(pcs_rx_d), .mac_rx_en(mac_rx_en), .mac_rx_er(mac_rx_er),
    .mac_rx_d(mac_rx_d), .mac_rx_valid(mac_rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_fac(input bit sg, input int sp);
    if (!sg) return 1;
    if (sp == 0) return 100;
    if (sp == 1) return 10;
    return 1;
  endfunction

  function automatic int pat(input int seed, input int i);
    return (seed + i * 37 + i * i * 3) & 255;
  endfunction

  task automatic set_speed(input bit sg, input int sp);
    @(negedge clk);
    sgmii_mode = sg;
    speed_sel  = sp[1:0];
    repeat (230) @(negedge clk);
  endtask

  task automatic measure(output int p);
    @(negedge clk);
    while (!mac_tx_take) @(negedge clk);
    @(negedge clk);
    p = 1;
    while (!mac_tx_take) begin
      @(negedge clk);
      p++;
    end
  endtask

  // Send n bytes through the transmit side with the bench in loopback, collect the receive side.
  task automatic tx_loop(input int n, input int seed, input int erridx, input int fac, input string req);
    int  cnt;
    bit  hold_ok, tk_ok;
    int  bad;
    cnt = 0;
    fork
      begin
        @(negedge clk);
        while (!mac_tx_take) @(negedge clk);
        for (int i = 0; i < n; i++) begin
          mac_tx_en = 1'b1;
          mac_tx_er = (i == erridx);
          mac_tx_d  = pat(seed, i);
          @(posedge clk);
          hold_ok = 1'b1;
          tk_ok   = 1'b1;
          bad     = 0;
          for (int k = 0; k < fac; k++) begin
            @(negedge clk);
            if (pcs_tx_en !== 1'b1 || pcs_tx_er !== (i == erridx) || pcs_tx_d !== 8'(pat(seed, i))) begin
              hold_ok = 1'b0;
              bad = pcs_tx_d;
            end
            if (mac_tx_take !== (k == fac - 1)) tk_ok = 1'b0;
          end
          chk(hold_ok, "R5", bad, pat(seed, i));
          chk(tk_ok, "R4", 0, fac);
        end
        mac_tx_en = 1'b0;
        mac_tx_er = 1'b0;
        mac_tx_d  = 8'h00;
      end
      begin
        repeat ((n + 2) * fac + 20) begin
          @(negedge clk);
          if (mac_rx_valid) begin
            if (cnt < 64) begin
              rec_d[cnt]  = mac_rx_d;
              rec_er[cnt] = mac_rx_er;
            end
            cnt++;
          end
        end
      end
    join
    chk(cnt == n, req, cnt, n);
    for (int i = 0; i < n && i < cnt; i++)
      chk(rec_d[i] == 8'(pat(seed, i)) && rec_er[i] == (i == erridx), req, rec_d[i], pat(seed, i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int p;
    int exp_list [0:3];
    bit exp_er [0:3];
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pcs_tx_en == 0 && pcs_tx_er == 0 && pcs_tx_d == 0, "R1", pcs_tx_d, 0);
    chk(mac_rx_en == 0 && mac_rx_er == 0 && mac_rx_d == 0 && mac_rx_valid == 0, "R1", mac_rx_d, 0);
    chk(mac_tx_take == 1'b1, "R1", mac_tx_take, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(pcs_tx_en == 0 && mac_rx_valid == 0 && mac_tx_take == 1'b1, "R1", pcs_tx_en, 0);

    // R2 / R3: exhaustive sweep of mode and speed code, measured as strobe period (R4)
    for (int sg = 0; sg < 2; sg++) begin
      for (int sp = 0; sp < 4; sp++) begin
        set_speed(sg[0], sp);
        measure(p);
        chk(p == exp_fac(sg[0], sp), (sg != 0) ? "R2" : "R3", p, exp_fac(sg[0], sp));
      end
    end

    // R10: loopback at each factor and in 1000BASE-X mode
    loop = 1'b1;
    set_speed(1'b1, 2);
    tx_loop(12, 17, 5, 1, "R10");
    set_speed(1'b1, 1);
    tx_loop(7, 99, 0, 10, "R10");
    set_speed(1'b1, 0);
    tx_loop(4, 200, 3, 100, "R10");
    set_speed(1'b0, 0);
    tx_loop(9, 3, 2, 1, "R10");

    // R6 / R7 / R8: directly driven receive frames at F = 10
    loop = 1'b0;
    set_speed(1'b1, 1);
    exp_list = '{8'h10, 8'h1A, 8'h40, 8'h4A};
    exp_er   = '{1'b0, 1'b1, 1'b0, 1'b0};
    rec_n = 0;
    fork
      begin
        for (int off = 0; off < 13; off++) begin
          @(negedge clk);
          drv_en = 1'b1; drv_er = (off == 10); drv_d = 8'(8'h10 + off);
        end
        @(negedge clk);
        drv_en = 1'b0; drv_er = 1'b0; drv_d = 8'h00;
        for (int off = 0; off < 12; off++) begin
          @(negedge clk);
          drv_en = 1'b1; drv_er = 1'b0; drv_d = 8'(8'h40 + off);
        end
        @(negedge clk);
        drv_en = 1'b0; drv_d = 8'h00;
        repeat (2) @(negedge clk);
        chk(mac_rx_en == 1'b0 && mac_rx_valid == 1'b0, "R7", mac_rx_en, 0);
      end
      begin
        repeat (45) begin
          @(negedge clk);
          if (mac_rx_valid) begin
            if (rec_n < 64) begin
              rec_d[rec_n]  = mac_rx_d;
              rec_er[rec_n] = mac_rx_er;
            end
            rec_n++;
          end
        end
      end
    join
    chk(rec_n == 4, "R6", rec_n, 4);
    for (int i = 0; i < 2 && i < rec_n; i++)
      chk(rec_d[i] == 8'(exp_list[i]) && rec_er[i] == exp_er[i], "R6", rec_d[i], exp_list[i]);
    for (int i = 2; i < 4 && i < rec_n; i++)
      chk(rec_d[i] == 8'(exp_list[i]) && rec_er[i] == exp_er[i], "R8", rec_d[i], exp_list[i]);

    // R9: request gigabit during a 100 Mb/s frame; the frame keeps factor 10
    loop = 1'b1;
    set_speed(1'b1, 1);
    fork
      tx_loop(6, 77, -1, 10, "R9");
      begin
        repeat (25) @(negedge clk);
        speed_sel = 2'b10;
      end
    join
    repeat (60) @(negedge clk);
    measure(p);
    chk(p == 1, "R9", p, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule